// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-and-ALU half of a small processor. Every transfer between storage elements crosses one shared internal bus. In a given cycle the bus carries the value of at most one source. The sources are the general register file, the program counter, the instruction register, the memory data register, the ALU result latch, and a literal value supplied by the control unit. Each destination has its own load strobe and captures the bus on the next rising clock edge.

The ALU takes its first operand from either the operand latch or a constant, selected by a control input. It takes its second operand from the bus. Its result can be stored only in the result latch, and that latch reaches the bus only when its own drive strobe is set.

On the memory side, the address register feeds the address lines. The memory data register can be loaded from the bus or from the incoming memory data, and it can be presented on the outgoing memory data lines. The data lines are split into an input and an output with an enable. Read and write requests stay raised until the memory answers with a function-complete pulse.

All sequencing and instruction decoding sit outside this block. The control unit drives every strobe directly.

Top module: `sbus_datapath`

## Requirements
- R1: After reset every register (four general registers, PC, IR, MAR, MDR, Y, Z), the N flag, and the read and write requests are zero.
- R2: With `rf_load` set, general register `rf_wr_sel` takes the bus value at the clock edge, and the other general registers keep their contents. With `rf_drive` set, register `rf_rd_sel` is placed on the bus.
- R3: The bus carries the value of the single active drive strobe. The strobes are `rf_drive`, `pc_drive`, `ir_drive`, `mdr_drive`, `z_drive` and `imm_drive`. With no strobe active the bus reads zero. `bus_conflict` is high in any cycle where two or more drive strobes are active, and low otherwise.
- R4: The ALU result is selected by `alu_func`. The codes are: 0 ADD (A+B+`alu_cin`), 1 SUB (A−B), 2 AND, 3 OR, 4 XOR, 5 pass B, 6 pass A. Any other code passes B. A is Y, or the constant zero when `alu_a_const` is set. B is the bus.
- R5: Z takes the ALU result only on a cycle with `z_load` set, and reaches the bus only through `z_drive`. N takes bit 15 of the ALU result at that same edge.
- R6: The PC can be incremented by one in two cycles. In the first cycle PC drives the bus, the A operand is the constant, the carry-in is set, ADD is selected and the result goes to Z. In the second cycle Z drives the bus and PC loads. An increment of 0xFFFF wraps to 0x0000.
- R7: `mar_load` captures the bus into MAR, and `mem_addr` always shows MAR.
- R8: `ctl_read` raises `mem_rd` from the next cycle, and it stays high until the edge at which `mfc` is seen. MDR takes `mem_rdata` only at an edge where both `mfc` and `mdr_mem_load` are high. While it waits without `mfc`, MDR is unchanged.
- R9: `ctl_write` raises `mem_wr` from the next cycle until the edge at which `mfc` is seen. `mem_wdata` shows MDR, and `mem_wdata_en` follows `mdr_mem_drive`.
- R10: `mdr_load` captures the bus into MDR. It takes priority over a simultaneous memory capture.
- R11: `ir_load` captures the bus into IR, `ir_q` shows IR, and `ir_drive` places IR on the bus.
- R12: A register-to-register add takes three cycles. Cycle 1 moves the first source to Y. Cycle 2 drives the second source with ADD and loads Z. Cycle 3 moves Z into the destination. The sum lands in the destination and both sources are unchanged.
- R13: A cycle without `z_load` leaves both Z and N unchanged, whatever the ALU inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_rd_sel | input | 2 | General register placed on the bus |
| rf_wr_sel | input | 2 | General register loaded from the bus |
| rf_drive | input | 1 | General register drives bus |
| rf_load | input | 1 | General register loads bus |
| pc_drive | input | 1 | PC drives bus |
| pc_load | input | 1 | PC loads bus |
| ir_drive | input | 1 | IR drives bus |
| ir_load | input | 1 | IR loads bus |
| imm_drive | input | 1 | Literal from control drives bus |
| imm_value | input | 16 | Literal value |
| mar_load | input | 1 | MAR loads bus |
| mdr_drive | input | 1 | MDR drives internal bus |
| mdr_load | input | 1 | MDR loads internal bus |
| mdr_mem_load | input | 1 | MDR loads memory data on MFC |
| mdr_mem_drive | input | 1 | MDR drives memory data lines |
| y_load | input | 1 | Y loads bus |
| alu_a_const | input | 1 | A operand is the constant instead of Y |
| alu_func | input | 4 | ALU function code |
| alu_cin | input | 1 | ALU carry-in for ADD |
| z_load | input | 1 | Z and N load ALU result |
| z_drive | input | 1 | Z drives bus |
| ctl_read | input | 1 | Start memory read |
| ctl_write | input | 1 | Start memory write |
| mfc | input | 1 | Memory function complete |
| mem_rdata | input | 16 | Data from memory |
| mem_addr | output | 16 | Memory address (MAR) |
| mem_wdata | output | 16 | Data to memory (MDR) |
| mem_wdata_en | output | 1 | Outgoing data valid |
| mem_rd | output | 1 | Read request pending |
| mem_wr | output | 1 | Write request pending |
| bus_o | output | 16 | Current internal bus value |
| ir_q | output | 16 | Instruction register |
| n_flag | output | 1 | Sign of last Z result |
| bus_conflict | output | 1 | More than one bus driver |

## Verification
The assertions assume a well-behaved memory: `mfc` is raised only while a read or write is pending, it is a single-cycle pulse, and `ctl_read` and `ctl_write` are never issued together. The bench's memory responder only raises `mfc` a fixed latency after it sees `mem_rd` or `mem_wr`. It drops `mfc` as soon as the request falls, and every control sequence issues one kind of access at a time. Apart from the dedicated conflict case, each stimulus cycle raises at most one drive strobe, so the bus-value checks never depend on how overlapping drivers would merge.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   // ALU function codes
   localparam int unsigned ALU_ADD   = 0;
   localparam int unsigned ALU_SUB   = 1;
   localparam int unsigned ALU_AND   = 2;
   localparam int unsigned ALU_OR    = 3;
   localparam int unsigned ALU_XOR   = 4;
   localparam int unsigned ALU_PASSB = 5;
   localparam int unsigned ALU_PASSA = 6;

   // bus source slots
   localparam int unsigned SRC_RF   = 0;
   localparam int unsigned SRC_PC   = 1;
   localparam int unsigned SRC_IR   = 2;
   localparam int unsigned SRC_MDR  = 3;
   localparam int unsigned SRC_Z    = 4;
   localparam int unsigned SRC_IMM  = 5;
   localparam int unsigned NSRC     = 6;

   // bus merge variants
   localparam int unsigned BUS_PRIORITY = 0;
   localparam int unsigned BUS_ANDOR    = 1;
endpackage

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux #(
   parameter int unsigned W     = 16,
   parameter int unsigned N     = 6,
   parameter int unsigned STYLE = 1
) (
   input  logic [N-1:0]        sel,
   input  logic [N-1:0][W-1:0] src,
   output logic [W-1:0]        bus,
   output logic                conflict
);
   import sbus_pkg::*;

   generate
      if (N < 2) begin : g_bad_n
         $error("sbus_bus_mux: N must be at least 2");
      end
      if (STYLE != BUS_PRIORITY && STYLE != BUS_ANDOR) begin : g_bad_style
         $error("sbus_bus_mux: unknown STYLE");
      end
   endgenerate

   // more than one bit set: clearing the lowest set bit leaves something
   assign conflict = |(sel & (sel - N'(1)));

   generate
      if (STYLE == BUS_ANDOR) begin : g_andor
         logic [N:0][W-1:0] acc;
         assign acc[0] = '0;
         for (genvar i = 0; i < N; i++) begin : g_term
            assign acc[i+1] = acc[i] | (src[i] & {W{sel[i]}});
         end
         assign bus = acc[N];
      end else begin : g_prio
         always_comb begin
            bus = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (sel[i]) bus = src[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
   parameter int unsigned W    = 16,
   parameter int unsigned NREG = 4,
   localparam int unsigned AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] raddr,
   input  logic [AW-1:0] waddr,
   input  logic          we,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   generate
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_depth
         $error("sbus_regfile: NREG must be a power of two >= 2");
      end
   endgenerate

   logic [NREG-1:0][W-1:0] regs;
   logic [NREG-1:0]        row_we;

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_dec
         assign row_we[i] = we && (waddr == AW'(i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (row_we[i]) regs[i] <= wdata;
         end
      end
   end

   assign rdata = regs[raddr];

   // R2: a write lands in the addressed row
   p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
   parameter int unsigned W  = 16,
   parameter int unsigned FW = 4
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   input  logic [FW-1:0] func,
   input  logic          cin,
   output logic [W-1:0]  y
);
   import sbus_pkg::*;

   generate
      if (FW < 3) begin : g_bad_fw
         $error("sbus_alu: function code needs at least 3 bits");
      end
   endgenerate

   always_comb begin
      case (int'(func))
         ALU_ADD:   y = a + b + W'(cin);
         ALU_SUB:   y = a - b;
         ALU_AND:   y = a & b;
         ALU_OR:    y = a | b;
         ALU_XOR:   y = a ^ b;
         ALU_PASSA: y = a;
         default:   y = b;
      endcase
   end
endmodule

// File: rtl/sbus_mdr.sv
module sbus_mdr #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_load,
   input  logic [W-1:0] bus_in,
   input  logic         mem_load,
   input  logic         mfc,
   input  logic [W-1:0] mem_rdata,
   output logic [W-1:0] q
);
   logic mem_take;
   assign mem_take = mem_load && mfc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (bus_load) q <= bus_in;
      else if (mem_take) q <= mem_rdata;
   end

   // R8: memory data captured on the completion edge
   p_mem_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_load && mfc && !bus_load) |=> q == $past(mem_rdata));
   // R8: waiting without completion leaves MDR alone
   p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_load && !mfc && !bus_load) |=> $stable(q));
   // R10: internal load wins over memory capture
   p_bus_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_load |=> q == $past(bus_in));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NREG      = 4,
   parameter int unsigned FUNC_W    = 4,
   parameter int unsigned CONST_A   = 0,
   parameter int unsigned BUS_STYLE = 1,
   localparam int unsigned RA_W     = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RA_W-1:0]   rf_rd_sel,
   input  logic [RA_W-1:0]   rf_wr_sel,
   input  logic              rf_drive,
   input  logic              rf_load,
   input  logic              pc_drive,
   input  logic              pc_load,
   input  logic              ir_drive,
   input  logic              ir_load,
   input  logic              imm_drive,
   input  logic [DATA_W-1:0] imm_value,
   input  logic              mar_load,
   input  logic              mdr_drive,
   input  logic              mdr_load,
   input  logic              mdr_mem_load,
   input  logic              mdr_mem_drive,
   input  logic              y_load,
   input  logic              alu_a_const,
   input  logic [FUNC_W-1:0] alu_func,
   input  logic              alu_cin,
   input  logic              z_load,
   input  logic              z_drive,
   input  logic              ctl_read,
   input  logic              ctl_write,
   input  logic              mfc,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wdata_en,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] bus_o,
   output logic [DATA_W-1:0] ir_q,
   output logic              n_flag,
   output logic              bus_conflict
);
   import sbus_pkg::*;

   localparam int unsigned MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] A_CONST = DATA_W'(CONST_A);

   generate
      if (DATA_W < 4) begin : g_bad_w
         $error("sbus_datapath: DATA_W must be at least 4");
      end
      if (FUNC_W < 3) begin : g_bad_fw
         $error("sbus_datapath: FUNC_W must be at least 3");
      end
   endgenerate

   logic [DATA_W-1:0] bus;
   logic [DATA_W-1:0] rf_rdata, pc_q, ir_r, mar_q, mdr_q, y_q, z_q, alu_a, alu_y;
   logic              rd_pend, wr_pend;
   logic [NSRC-1:0]              drv;
   logic [NSRC-1:0][DATA_W-1:0]  src;

   // ---------------- bus sources ----------------
   always_comb begin
      drv           = '0;
      drv[SRC_RF]   = rf_drive;
      drv[SRC_PC]   = pc_drive;
      drv[SRC_IR]   = ir_drive;
      drv[SRC_MDR]  = mdr_drive;
      drv[SRC_Z]    = z_drive;
      drv[SRC_IMM]  = imm_drive;
      src           = '0;
      src[SRC_RF]   = rf_rdata;
      src[SRC_PC]   = pc_q;
      src[SRC_IR]   = ir_r;
      src[SRC_MDR]  = mdr_q;
      src[SRC_Z]    = z_q;
      src[SRC_IMM]  = imm_value;
   end

   sbus_bus_mux #(.W(DATA_W), .N(NSRC), .STYLE(BUS_STYLE)) u_mux (
      .sel      (drv),
      .src      (src),
      .bus      (bus),
      .conflict (bus_conflict)
   );

   // ---------------- general registers ----------------
   sbus_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .raddr (rf_rd_sel),
      .waddr (rf_wr_sel),
      .we    (rf_load),
      .wdata (bus),
      .rdata (rf_rdata)
   );

   // ---------------- ALU ----------------
   assign alu_a = alu_a_const ? A_CONST : y_q;

   sbus_alu #(.W(DATA_W), .FW(FUNC_W)) u_alu (
      .a    (alu_a),
      .b    (bus),
      .func (alu_func),
      .cin  (alu_cin),
      .y    (alu_y)
   );

   // ---------------- memory data register ----------------
   sbus_mdr #(.W(DATA_W)) u_mdr (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_load  (mdr_load),
      .bus_in    (bus),
      .mem_load  (mdr_mem_load),
      .mfc       (mfc),
      .mem_rdata (mem_rdata),
      .q         (mdr_q)
   );

   // ---------------- special registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         ir_r   <= '0;
         mar_q  <= '0;
         y_q    <= '0;
         z_q    <= '0;
         n_flag <= 1'b0;
      end else begin
         if (pc_load)  pc_q  <= bus;
         if (ir_load)  ir_r  <= bus;
         if (mar_load) mar_q <= bus;
         if (y_load)   y_q   <= bus;
         if (z_load) begin
            z_q    <= alu_y;
            n_flag <= alu_y[MSB];
         end
      end
   end

   // ---------------- memory request tracking ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         wr_pend <= 1'b0;
      end else begin
         if (ctl_read)     rd_pend <= 1'b1;
         else if (mfc)     rd_pend <= 1'b0;
         if (ctl_write)    wr_pend <= 1'b1;
         else if (mfc)     wr_pend <= 1'b0;
      end
   end

   assign mem_addr     = mar_q;
   assign mem_wdata    = mdr_q;
   assign mem_wdata_en = mdr_mem_drive;
   assign mem_rd       = rd_pend;
   assign mem_wr       = wr_pend;
   assign bus_o        = bus;
   assign ir_q         = ir_r;

   // ---------------- assertions ----------------
   // R3: an undriven bus reads zero
   p_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drv == '0) |-> (bus_o == '0));
   // R3: a lone PC drive shows PC without conflict
   p_single_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drv == NSRC'(1 << SRC_PC)) |-> (bus_o == pc_q && !bus_conflict));
   // R7: address lines follow the last MAR load
   p_mar_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mar_load |=> mem_addr == $past(bus_o));
   // R5 / R13: Z and N hold without z_load
   p_z_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !z_load |=> ($stable(z_q) && $stable(n_flag)));
   // R5: N mirrors the sign of the captured Z
   p_n_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      z_load |=> n_flag == z_q[MSB]);
   // R8: read request held until completion
   p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mfc) |=> mem_rd);
   p_rd_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mfc && !ctl_read) |=> !mem_rd);
   // R9: write request held until completion
   p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mfc) |=> mem_wr);
   p_wr_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && mfc && !ctl_write) |=> !mem_wr);
   // R11: IR captures the bus
   p_ir_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ir_load |=> ir_q == $past(bus_o));
endmodule

// File: tb/tb_sbus_datapath.sv
`timescale 1ns/1ps
module tb_sbus_datapath;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  rf_rd_sel = '0, rf_wr_sel = '0;
   logic        rf_drive = 0, rf_load = 0, pc_drive = 0, pc_load = 0;
   logic        ir_drive = 0, ir_load = 0, imm_drive = 0;
   logic [15:0] imm_value = '0;
   logic        mar_load = 0, mdr_drive = 0, mdr_load = 0, mdr_mem_load = 0, mdr_mem_drive = 0;
   logic        y_load = 0, alu_a_const = 0, alu_cin = 0, z_load = 0, z_drive = 0;
   logic [3:0]  alu_func = '0;
   logic        ctl_read = 0, ctl_write = 0, mfc = 0;
   logic [15:0] mem_rdata = 16'hDEAD;
   logic [15:0] mem_addr, mem_wdata, bus_o, ir_q;
   logic        mem_wdata_en, mem_rd, mem_wr, n_flag, bus_conflict;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sbus_datapath dut (
      .clk(clk), .rst_n(rst_n), .rf_rd_sel(rf_rd_sel), .rf_wr_sel(rf_wr_sel),
      .rf_drive(rf_drive), .rf_load(rf_load), .pc_drive(pc_drive), .pc_load(pc_load),
      .ir_drive(ir_drive), .ir_load(ir_load), .imm_drive(imm_drive), .imm_value(imm_value),
      .mar_load(mar_load), .mdr_drive(mdr_drive), .mdr_load(mdr_load),
      .mdr_mem_load(mdr_mem_load), .mdr_mem_drive(mdr_mem_drive), .y_load(y_load),
      .alu_a_const(alu_a_const), .alu_func(alu_func), .alu_cin(alu_cin),
      .z_load(z_load), .z_drive(z_drive), .ctl_read(ctl_read), .ctl_write(ctl_write),
      .mfc(mfc), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_wdata_en(mem_wdata_en), .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_o(bus_o),
      .ir_q(ir_q), .n_flag(n_flag), .bus_conflict(bus_conflict)
   );

   // ---------------- memory responder ----------------
   localparam int LAT = 2;
   logic [15:0] mem [16];
   int          wait_cnt = 0;

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 16'h1000 + 16'(i) * 16'h0111;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         mfc = 0; wait_cnt = 0; mem_rdata = 16'hDEAD;
      end else if ((mem_rd || mem_wr) && !mfc) begin
         wait_cnt++;
         if (wait_cnt >= LAT) begin
            mfc = 1;
            if (mem_rd) mem_rdata = mem[mem_addr[3:0]];
            if (mem_wr && mem_wdata_en) mem[mem_addr[3:0]] = mem_wdata;
         end else begin
            mem_rdata = 16'hDEAD;
         end
      end else begin
         mfc = 0; wait_cnt = 0; mem_rdata = 16'hDEAD;
      end
   end

   // ---------------- helpers ----------------
   task automatic cyc();
      @(negedge clk); #1;
   endtask

   task automatic idle();
      rf_drive = 0; rf_load = 0; pc_drive = 0; pc_load = 0; ir_drive = 0; ir_load = 0;
      imm_drive = 0; mar_load = 0; mdr_drive = 0; mdr_load = 0; mdr_mem_load = 0;
      mdr_mem_drive = 0; y_load = 0; alu_a_const = 0; alu_cin = 0; z_load = 0;
      z_drive = 0; ctl_read = 0; ctl_write = 0; alu_func = 4'd5;
   endtask

   task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic put_reg(int idx, logic [15:0] v);
      idle(); imm_drive = 1; imm_value = v; rf_wr_sel = 2'(idx); rf_load = 1; cyc(); idle();
   endtask

   task automatic peek_reg(int idx, output logic [15:0] v);
      idle(); rf_rd_sel = 2'(idx); rf_drive = 1; #1; v = bus_o; idle();
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [15:0] v;
      idle(); #1;
      chk("R1", "idle bus", bus_o, 16'h0);
      chk("R3", "idle bus", bus_o, 16'h0);
      for (int i = 0; i < 4; i++) begin
         peek_reg(i, v); chk("R1", "gpr", v, 16'h0);
      end
      pc_drive = 1; #1; chk("R1", "pc", bus_o, 16'h0); idle();
      ir_drive = 1; #1; chk("R1", "ir", bus_o, 16'h0); idle();
      mdr_drive = 1; #1; chk("R1", "mdr", bus_o, 16'h0); idle();
      z_drive = 1; #1; chk("R1", "z", bus_o, 16'h0); idle();
      alu_func = 4'd6; z_load = 1; cyc(); idle(); z_drive = 1; #1;
      chk("R1", "y via pass-a", bus_o, 16'h0); idle();
      chk("R1", "ir_q", ir_q, 16'h0);
      chk("R1", "mar", mem_addr, 16'h0);
      chk("R1", "n", 16'(n_flag), 16'h0);
      chk("R1", "rd/wr", {14'b0, mem_rd, mem_wr}, 16'h0);
   endtask

   task automatic t_regfile();
      logic [15:0] v;
      for (int i = 0; i < 4; i++) put_reg(i, 16'hA000 + 16'(i * 17));
      put_reg(2, 16'h5A5A);
      for (int i = 0; i < 4; i++) begin
         peek_reg(i, v);
         chk("R2", "gpr readback", v, (i == 2) ? 16'h5A5A : 16'hA000 + 16'(i * 17));
      end
   endtask

   task automatic t_conflict();
      idle(); imm_drive = 1; imm_value = 16'h1234; #1;
      chk("R3", "single driver value", bus_o, 16'h1234);
      chk("R3", "single driver flag", 16'(bus_conflict), 16'h0);
      pc_drive = 1; #1;
      chk("R3", "two drivers flag", 16'(bus_conflict), 16'h1);
      idle(); z_drive = 1; rf_drive = 1; mdr_drive = 1; #1;
      chk("R3", "three drivers flag", 16'(bus_conflict), 16'h1);
      idle(); #1;
      chk("R3", "no driver flag", 16'(bus_conflict), 16'h0);
   endtask

   task automatic alu_case(logic [3:0] f, logic cin, logic ac, logic [15:0] exp, logic expn);
      idle(); imm_drive = 1; imm_value = 16'h0F3C; alu_func = f; alu_cin = cin;
      alu_a_const = ac; z_load = 1; cyc(); idle();
      z_drive = 1; #1;
      chk("R4", $sformatf("alu func %0d", f), bus_o, exp);
      chk("R5", "n flag", 16'(n_flag), 16'(expn));
      idle();
   endtask

   task automatic t_alu();
      idle(); imm_drive = 1; imm_value = 16'h00F0; y_load = 1; cyc(); idle();
      alu_case(4'd0, 0, 0, 16'h102C, 0);
      alu_case(4'd0, 1, 0, 16'h102D, 0);
      alu_case(4'd1, 0, 0, 16'hF1B4, 1);
      // R13: no z_load, Z and N held
      idle(); imm_drive = 1; imm_value = 16'h0001; alu_func = 4'd0; cyc(); idle();
      z_drive = 1; #1;
      chk("R13", "z held", bus_o, 16'hF1B4);
      chk("R13", "n held", 16'(n_flag), 16'h1);
      idle();
      alu_case(4'd2, 0, 0, 16'h0030, 0);
      alu_case(4'd3, 0, 0, 16'h0FFC, 0);
      alu_case(4'd4, 0, 0, 16'h0FCC, 0);
      alu_case(4'd5, 0, 0, 16'h0F3C, 0);
      alu_case(4'd6, 0, 0, 16'h00F0, 0);
      alu_case(4'd9, 0, 0, 16'h0F3C, 0);
      alu_case(4'd0, 0, 1, 16'h0F3C, 0);
      alu_case(4'd6, 0, 1, 16'h0000, 0);
   endtask

   task automatic pc_inc(logic [15:0] start, logic [15:0] exp);
      idle(); imm_drive = 1; imm_value = start; pc_load = 1; cyc(); idle();
      pc_drive = 1; alu_a_const = 1; alu_cin = 1; alu_func = 4'd0; z_load = 1; cyc(); idle();
      pc_drive = 1; #1; chk("R6", "pc before write-back", bus_o, start); idle();
      z_drive = 1; pc_load = 1; cyc(); idle();
      pc_drive = 1; #1; chk("R6", "pc incremented", bus_o, exp); idle();
   endtask

   task automatic t_pc();
      pc_inc(16'h00FF, 16'h0100);
      pc_inc(16'hFFFF, 16'h0000);
   endtask

   task automatic t_ir();
      idle(); imm_drive = 1; imm_value = 16'hA5C3; ir_load = 1; cyc(); idle();
      chk("R11", "ir_q", ir_q, 16'hA5C3);
      ir_drive = 1; #1; chk("R11", "ir on bus", bus_o, 16'hA5C3); idle();
   endtask

   task automatic t_read();
      int n;
      idle(); imm_drive = 1; imm_value = 16'h1111; mdr_load = 1; cyc(); idle();
      mdr_drive = 1; #1; chk("R10", "mdr bus load", bus_o, 16'h1111); idle();
      imm_drive = 1; imm_value = 16'h0005; mar_load = 1; ctl_read = 1; cyc(); idle();
      chk("R7", "mem_addr", mem_addr, 16'h0005);
      chk("R8", "mem_rd raised", 16'(mem_rd), 16'h1);
      mdr_mem_load = 1; mdr_drive = 1;
      n = 0;
      while (!mfc && n < 10) begin
         #1; chk("R8", "mdr held while waiting", bus_o, 16'h1111);
         chk("R8", "mem_rd held", 16'(mem_rd), 16'h1);
         cyc(); n++;
      end
      cyc();
      chk("R8", "mem_rd dropped", 16'(mem_rd), 16'h0);
      chk("R8", "mdr captured", bus_o, mem[5]);
      idle();
      // R10: bus load beats memory capture on the completion edge
      imm_drive = 1; imm_value = 16'h0006; mar_load = 1; ctl_read = 1; cyc(); idle();
      n = 0;
      while (!mfc && n < 10) begin cyc(); n++; end
      imm_drive = 1; imm_value = 16'h2222; mdr_load = 1; mdr_mem_load = 1; cyc(); idle();
      mdr_drive = 1; #1; chk("R10", "bus load priority", bus_o, 16'h2222); idle();
      chk("R8", "mem_rd dropped again", 16'(mem_rd), 16'h0);
   endtask

   task automatic t_write();
      int n;
      idle(); imm_drive = 1; imm_value = 16'hBEEF; mdr_load = 1; cyc(); idle();
      imm_drive = 1; imm_value = 16'h0009; mar_load = 1; ctl_write = 1; cyc(); idle();
      chk("R9", "mem_wdata_en off", 16'(mem_wdata_en), 16'h0);
      chk("R9", "mem_wr raised", 16'(mem_wr), 16'h1);
      mdr_mem_drive = 1; #1;
      chk("R9", "mem_wdata_en on", 16'(mem_wdata_en), 16'h1);
      chk("R9", "mem_wdata", mem_wdata, 16'hBEEF);
      n = 0;
      while (!mfc && n < 10) begin
         chk("R9", "mem_wr held", 16'(mem_wr), 16'h1);
         cyc(); n++;
      end
      cyc(); idle();
      chk("R9", "mem_wr dropped", 16'(mem_wr), 16'h0);
      chk("R9", "memory written", mem[9], 16'hBEEF);
   endtask

   task automatic t_add_seq();
      logic [15:0] v;
      put_reg(1, 16'h1234); put_reg(2, 16'h0101); put_reg(3, 16'hFFFF);
      idle(); rf_rd_sel = 2'd1; rf_drive = 1; y_load = 1; cyc(); idle();
      rf_rd_sel = 2'd2; rf_drive = 1; alu_func = 4'd0; z_load = 1; cyc(); idle();
      peek_reg(3, v); chk("R12", "dest untouched before step 3", v, 16'hFFFF);
      z_drive = 1; rf_wr_sel = 2'd3; rf_load = 1; cyc(); idle();
      peek_reg(3, v); chk("R12", "sum in dest", v, 16'h1335);
      peek_reg(1, v); chk("R12", "src1 kept", v, 16'h1234);
      peek_reg(2, v); chk("R12", "src2 kept", v, 16'h0101);
   endtask

   // ---------------- main ----------------
   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      t_reset();
      t_regfile();
      t_conflict();
      t_alu();
      t_pc();
      t_ir();
      t_read();
      t_write();
      t_add_seq();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule